// File: doc/BRIEF.md
# Ling Lookahead Adder

This block adds two unsigned binary words and an incoming carry, producing the word-wide sum and the carry leaving the top bit. Instead of the usual generate/propagate carry chain, it carries Ling pseudo-carries. A pseudo-carry at a bit is set when that bit generates, or when the bit below transmits (OR of the operand bits) and the pseudo-carry below is set. The real carry is rebuilt only where a sum bit needs it, as the transmit of that bit ANDed with its pseudo-carry.

Bits are split into lookahead groups of `GRP` bits. Each group builds its local pseudo-generate in reduced Ling form and its group transmit, which is the AND of the transmits that feed into the group. A second lookahead level turns these per-group pairs and the carry-in into the pseudo-carry that enters every group and the pseudo-carry at the top bit. The carry-in acts as the pseudo-carry below bit 0, and the transmit below bit 0 is taken as 1. With `OUT_REG` set to 1 (the default), sum and carry-out are registered and appear one clock after the operands are sampled. A synchronous active-high reset clears them.

Top module: `ling_adder`

## Requirements
- R1: When `rst` is high at a rising clock edge, `sum` and `cout` read zero after that edge, whatever the operands are.
- R2: One clock after the operands and carry-in are sampled, `sum` equals bits WIDTH-1..0 of `op_a + op_b + cin`.
- R3: In the same cycle, `cout` equals bit WIDTH of `op_a + op_b + cin`.
- R4: The carry-in enters below bit 0: with both operands zero, `sum` equals `cin` and `cout` is 0.
- R5: A carry that enters at bit 0 crosses every group. All-ones plus a 1 on either operand or on `cin` gives a zero `sum` and `cout` = 1. All-ones plus all-ones plus 1 gives an all-ones `sum` and `cout` = 1.
- R6: When one operand is the bitwise complement of the other (for example 0xAAAAAAAA and 0x55555555), `sum` is all ones and `cout` is 0 if `cin` = 0, and `sum` is zero and `cout` is 1 if `cin` = 1.
- R7: The real carry entering each group (its lower-neighbour transmit ANDed with the pseudo-carry from the second level) equals the carry a plain ripple chain produces at that bit boundary. This includes carries generated at the top bit of a group and carries that run across several groups.
- R8: A new operand pair is accepted on every clock, and results come out in the same order, one per clock, with no bubbles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the outputs |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| cin | input | 1 | Incoming carry, used as the pseudo-carry below bit 0 |
| sum | output | WIDTH | Sum word, registered when OUT_REG = 1 |
| cout | output | 1 | Carry out of the top bit, registered when OUT_REG = 1 |

## Verification
On every clock, the assertions compare the combinational Ling sum and carry-out with an arithmetic reference, and compare each group's rebuilt entry carry with an independent ripple chain. They also check the zero-operand and complementary-operand identities, and that the outputs are clear after a reset cycle. Only the bench scenarios can show the one-cycle register latency with results in order under back-to-back input. The same holds for reset overriding nonzero operands at the ports and for the long carry runs produced by chosen corner vectors.

// File: rtl/ling_adder_pkg.sv
package ling_adder_pkg;
  // Per-group pair handed to the second lookahead level
  typedef struct packed {
    logic hg;  // local pseudo-generate of the group's top bit
    logic tg;  // AND of the transmits feeding the group
  } grp_sig_t;
endpackage

// File: rtl/ling_pg_stage.sv
module ling_pg_stage #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] g,
  output logic [WIDTH-1:0] t,
  output logic [WIDTH-1:0] x
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign g[i] = a[i] & b[i];
    assign t[i] = a[i] | b[i];
    assign x[i] = a[i] ^ b[i];
  end
endmodule

// File: rtl/ling_group.sv
module ling_group
  import ling_adder_pkg::*;
#(
  parameter int GRP = 4
) (
  input  logic [GRP-1:0] g,
  input  logic [GRP-1:0] t,
  input  logic [GRP-1:0] x,
  input  logic           t_below,
  input  logic           h_below,
  output logic [GRP-1:0] s,
  output grp_sig_t       grp
);
  logic [GRP-1:0] hloc;
  logic [GRP-1:0] tprod;
  logic [GRP-2:0] h;

  // AND of tv[lo..hi]; an empty span yields 1
  function automatic logic t_span(input logic [GRP-1:0] tv, input int lo, input int hi);
    logic r;
    r = 1'b1;
    for (int l = 0; l < GRP; l++) begin
      if (l >= lo && l <= hi) r = r & tv[l];
    end
    return r;
  endfunction

  always_comb begin
    for (int k = 0; k < GRP; k++) begin
      // reduced Ling form: g[m] needs only the transmits strictly between m and k
      hloc[k] = 1'b0;
      for (int m = 0; m <= k; m++) begin
        hloc[k] = hloc[k] | (g[m] & t_span(t, m + 1, k - 1));
      end
      tprod[k] = t_below & t_span(t, 0, k - 1);
    end
    for (int k = 0; k < GRP - 1; k++) begin
      h[k] = hloc[k] | (tprod[k] & h_below);
    end
    // real carry rebuilt only at each sum bit
    s[0] = x[0] ^ (t_below & h_below);
    for (int k = 1; k < GRP; k++) begin
      s[k] = x[k] ^ (t[k-1] & h[k-1]);
    end
    grp.hg = hloc[GRP-1];
    grp.tg = tprod[GRP-1];
  end
endmodule

// File: rtl/ling_lookahead.sv
module ling_lookahead #(
  parameter int NGRP = 8
) (
  input  logic [NGRP-1:0] hg,
  input  logic [NGRP-1:0] tg,
  input  logic            cin,
  output logic [NGRP-1:0] hin,
  output logic            h_out
);
  // pseudo-carry leaving group j-1, in flat sum-of-products form
  function automatic logic h_at(input logic [NGRP-1:0] hv, input logic [NGRP-1:0] tv,
                                input logic c, input int j);
    logic acc;
    logic prod;
    prod = c;
    for (int l = 0; l < NGRP; l++) begin
      if (l < j) prod = prod & tv[l];
    end
    acc = prod;
    for (int m = 0; m < NGRP; m++) begin
      if (m < j) begin
        prod = hv[m];
        for (int l = 0; l < NGRP; l++) begin
          if (l > m && l < j) prod = prod & tv[l];
        end
        acc = acc | prod;
      end
    end
    return acc;
  endfunction

  always_comb begin
    for (int j = 0; j < NGRP; j++) begin
      hin[j] = h_at(hg, tg, cin, j);
    end
    h_out = h_at(hg, tg, cin, NGRP);
  end
endmodule

// File: rtl/ling_adder.sv
module ling_adder
  import ling_adder_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int GRP     = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NGRP = WIDTH / GRP;

  logic [WIDTH-1:0] g, t, x;
  logic [WIDTH-1:0] ling_sum;
  logic             ling_cout;
  logic             h_top;
  logic [NGRP-1:0]  hg, tg, hin, t_below;
  grp_sig_t         grp_sig [NGRP];

  ling_pg_stage #(.WIDTH(WIDTH)) u_pg (
    .a(op_a), .b(op_b), .g(g), .t(t), .x(x)
  );

  for (genvar j = 0; j < NGRP; j++) begin : g_grp
    if (j == 0) begin : g_first
      assign t_below[j] = 1'b1;
    end else begin : g_rest
      assign t_below[j] = t[j*GRP-1];
    end
    ling_group #(.GRP(GRP)) u_grp (
      .g(g[j*GRP +: GRP]),
      .t(t[j*GRP +: GRP]),
      .x(x[j*GRP +: GRP]),
      .t_below(t_below[j]),
      .h_below(hin[j]),
      .s(ling_sum[j*GRP +: GRP]),
      .grp(grp_sig[j])
    );
    assign hg[j] = grp_sig[j].hg;
    assign tg[j] = grp_sig[j].tg;
  end

  ling_lookahead #(.NGRP(NGRP)) u_la (
    .hg(hg), .tg(tg), .cin(cin), .hin(hin), .h_out(h_top)
  );

  assign ling_cout = t[WIDTH-1] & h_top;

  if (OUT_REG) begin : g_oreg
    always_ff @(posedge clk) begin
      if (rst) begin
        sum  <= '0;
        cout <= 1'b0;
      end else begin
        sum  <= ling_sum;
        cout <= ling_cout;
      end
    end
    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (sum == '0 && !cout))
      else $error("outputs not cleared after reset");
  end else begin : g_comb
    assign sum  = ling_sum;
    assign cout = ling_cout;
  end

  // ---------------- checking references (independent of Ling nets) -----
  logic [WIDTH:0]  ref_sum;
  logic [NGRP-1:0] conv_entry;
  logic            conv_out;
  logic            rc;

  assign ref_sum = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, cin};

  always_comb begin
    conv_entry = '0;
    rc = cin;
    for (int i = 0; i < WIDTH; i++) begin
      if (i % GRP == 0) conv_entry[i/GRP] = rc;
      rc = (op_a[i] & op_b[i]) | ((op_a[i] | op_b[i]) & rc);
    end
    conv_out = rc;
  end

  // R2
  sum_ref_chk: assert property (@(posedge clk) disable iff (rst)
    ling_sum == ref_sum[WIDTH-1:0])
    else $error("Ling sum differs from arithmetic reference");

  // R3
  cout_ref_chk: assert property (@(posedge clk) disable iff (rst)
    (ling_cout == ref_sum[WIDTH]) && (ling_cout == conv_out))
    else $error("Ling carry-out differs from reference");

  // R7
  grp_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (t_below & hin) == conv_entry)
    else $error("group entry carry differs from ripple carry");

  // R4
  cin_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (op_a == '0 && op_b == '0) |-> (ling_sum == {{(WIDTH-1){1'b0}}, cin} && !ling_cout))
    else $error("carry-in not placed below bit 0");

  // R6
  compl_chk: assert property (@(posedge clk) disable iff (rst)
    (op_a == ~op_b) |-> (ling_sum == {WIDTH{~cin}} && ling_cout == cin))
    else $error("complementary operands give wrong result");
endmodule

// File: tb/ling_adder_tb_top.sv
`timescale 1ns/1ps
module ling_adder_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '1;
  logic [W-1:0] op_b = 32'h1;
  logic         cin = 1'b1;
  logic [W-1:0] sum;
  logic         cout;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [W-1:0] s;
    logic         c;
    string        tag;
  } exp_t;
  exp_t scb[$];

  always #2 clk = ~clk;  // 250 MHz

  ling_adder #(.WIDTH(W), .GRP(4), .OUT_REG(1'b1)) dut_i (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .cin(cin),
    .sum(sum), .cout(cout)
  );

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic ci, input string tag);
    logic [W:0] r;
    exp_t e;
    @(negedge clk);
    op_a = a; op_b = b; cin = ci;
    r = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    e.s = r[W-1:0]; e.c = r[W]; e.tag = tag;
    scb.push_back(e);
  endtask

  task automatic check_zero(input string tag);
    n_tests++;
    if (sum !== '0 || cout !== 1'b0) begin
      n_fail++;
      $display("FAIL %s: sum=%h cout=%b expected sum=%h cout=0", tag, sum, cout, {W{1'b0}});
    end
  endtask

  // monitor: the register captures at posedge; sample 1 ns later
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (scb.size() > 0) begin
        exp_t e;
        e = scb.pop_front();
        n_tests++;
        if (sum !== e.s || cout !== e.c) begin
          n_fail++;
          $display("FAIL %s: sum=%h cout=%b expected sum=%h cout=%b",
                   e.tag, sum, cout, e.s, e.c);
        end
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset dominates nonzero operands
    repeat (3) @(posedge clk);
    #1;
    check_zero("R1 reset with operands applied");
    @(negedge clk);
    rst = 1'b0;

    // R4
    drive(32'h0, 32'h0, 1'b1, "R4 zero operands cin=1");
    drive(32'h0, 32'h0, 1'b0, "R4 zero operands cin=0");
    // R5
    drive(32'hFFFF_FFFF, 32'h1, 1'b0, "R5 all-ones plus one");
    drive(32'hFFFF_FFFF, 32'h0, 1'b1, "R5 all-ones plus cin");
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R5 all-ones doubled plus cin");
    // R6
    drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R6 alternating cin=0");
    drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R6 alternating cin=1");
    drive(32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0, "R6 alternating doubled");
    // R7: group-boundary and multi-group carries
    drive(32'h0000_000F, 32'h1, 1'b0, "R7 carry out of group 0");
    drive(32'h0000_0FFF, 32'h1, 1'b0, "R7 run across three groups");
    drive(32'h0000_FFF0, 32'h0000_0010, 1'b0, "R7 generate in group 1");
    drive(32'h7FFF_FFFF, 32'h0, 1'b1, "R7 cin run to top bit");
    drive(32'h0800_0000, 32'h0800_0000, 1'b0, "R7 generate at group top");
    // R8: back-to-back stream
    for (int i = 0; i < 40; i++) begin
      drive(32'h1000_0000 * i + i, 32'hF000_0003 * i, i[0], "R8 back-to-back stream");
    end
    // R2 / R3: random vectors
    for (int i = 0; i < 300; i++) begin
      drive($urandom, $urandom, 1'($urandom), "R2/R3 random");
    end

    // drain the scoreboard
    while (scb.size() > 0) @(posedge clk);
    @(negedge clk);

    // R1: reset asserted mid-operation
    op_a = 32'hFFFF_FFFF; op_b = 32'hFFFF_FFFF; cin = 1'b1;
    rst = 1'b1;
    @(posedge clk);
    #1;
    check_zero("R1 reset during operation");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule